// File: doc/BRIEF.md
# Latency-Matched Hit Buffer Pool

This block sits below a pixel array's column scanner and stores hit records (pixel address, leading-edge stamp, trailing-edge stamp) in a pool of 24 slots. A record stays in its slot until a programmable trigger latency has passed since its leading-edge stamp. At that moment the block looks up whether a first-level trigger was seen for that record's time slot. If one was, the record is marked ready and leaves through a valid/ready output port as one parallel word. If none was, the slot is freed and the record is dropped.

Triggers come from an external input or, in self-trigger mode, from the global-OR hit line. A global-OR pulse schedules a trigger for the latency value later. Triggers are kept as a history with one bit per 7-bit time slot, so any number of triggers can be outstanding at the same time. The block has its own 7-bit free-running time base, which it publishes so that the scanner can stamp its hits.

Top module: `hit_latency_pool`

## Requirements
- R1: `hit_ready` is high exactly when at least one of the 24 slots is free; a record offered with `hit_valid` while `hit_ready` is high is stored in the lowest-numbered free slot on that clock edge.
- R2: With latency L (1 to 127), a stored record whose leading stamp is S is marked ready on the edge where `time_now` equals (S + L + 1) mod 128, if a trigger was taken on the edge where `time_now` was (S + L) mod 128.
- R3: A record with no trigger at (S + L) mod 128 is freed at (S + L + 1) mod 128 and never appears on the output.
- R4: `out_valid` is high while any slot holds a ready record; the output shows the ready record in the lowest-numbered slot with its address, leading stamp and trailing stamp unchanged, and that slot is freed on an edge where `out_ready` is high.
- R5: `ovf_count` increases by one on every edge on which no slot is free, saturates at its maximum, and is otherwise unchanged.
- R6: When `cfg_self_trig` is high, a `gor_in` pulse taken at time T acts as a trigger at time (T + L) mod 128; when `cfg_self_trig` is low, `gor_in` has no effect.
- R7: Triggers for several distinct time slots can be outstanding at once, and each selects only the records stamped with its own slot.
- R8: `time_now` is 0 after reset and increases by one, modulo 128, on every clock edge.
- R9: During reset, `hit_ready` is high, `out_valid` is low, `ovf_count` is zero and `time_now` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_latency | input | 7 | Trigger latency L in clocks, 1 to 127 |
| cfg_self_trig | input | 1 | Enables triggers made from the global-OR line |
| trig_in | input | 1 | External trigger, one clock per trigger |
| gor_in | input | 1 | Global-OR hit pulse |
| hit_valid | input | 1 | Incoming record offered |
| hit_ready | output | 1 | A slot is free to take the record |
| hit_addr | input | 12 | Pixel address of incoming record |
| hit_lead | input | 7 | Leading-edge stamp |
| hit_trail | input | 7 | Trailing-edge stamp |
| out_valid | output | 1 | A ready record is on the output |
| out_ready | input | 1 | Consumer takes the output record |
| out_addr | output | 12 | Address of the output record |
| out_lead | output | 7 | Leading stamp of the output record |
| out_trail | output | 7 | Trailing stamp of the output record |
| time_now | output | 7 | Current value of the time base |
| ovf_count | output | 16 | Clocks spent with the pool full |

## Verification
The assertions follow, on every cycle, the properties that depend only on the block's state: the pool being full forces `hit_ready` low, a ready record is not lost while `out_ready` is low, the overflow counter either stays or steps, and the time base steps by one. Whether a given record is kept or dropped depends on when its trigger arrived relative to its own stamp, and only the bench's scenarios show this: selective external triggers, a full pool draining under a toggling consumer, self-triggers with the mode switched off part way through, and latencies of 1 and 127 across the wrap of the time base.

// File: rtl/hit_pool_pkg.sv
// Shared definitions for the latency-matched hit buffer pool.
// Assumes: all modules of the pool import this package.
package hit_pool_pkg;

    localparam int DEF_SLOTS  = 24;
    localparam int DEF_TS_W   = 7;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_OVF_W  = 16;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/hp_trigger_track.sv
// Time base and trigger history for the hit buffer pool.
// Keeps a free-running stamp counter, records for every time slot whether a
// trigger selected it, and turns global-OR pulses into delayed triggers.
// Assumes: lat is between 1 and 2**TS_W-1 and held steady while records wait.
module hp_trigger_track #(
    parameter int TS_W = hit_pool_pkg::DEF_TS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TS_W-1:0]        lat,
    input  logic                   self_en,
    input  logic                   trig_in,
    input  logic                   gor_in,
    output logic [TS_W-1:0]        tnow,
    output logic [(1<<TS_W)-1:0]   hist
);
    localparam int DEPTH = 1 << TS_W;

    logic [DEPTH-1:0] pend_q;
    logic             trig_eff;
    logic [TS_W-1:0]  hit_slot;
    logic [TS_W-1:0]  fire_slot;

    assign trig_eff  = trig_in | (self_en & pend_q[tnow]);
    assign hit_slot  = tnow - lat;
    assign fire_slot = tnow + lat;

    // Free-running stamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tnow <= '0;
        else        tnow <= tnow + 1'b1;
    end

    // Write this cycle's trigger decision into the slot it selects.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist[hit_slot] <= trig_eff;
    end

    // Self-trigger schedule: consume the current slot, book a future one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q[tnow] <= 1'b0;
            if (self_en && gor_in) pend_q[fire_slot] <= 1'b1;
        end
    end

endmodule

// File: rtl/hp_first_set.sv
// Lowest-index selector: returns a one-hot vector of the lowest set request.
// Assumes: nothing; purely combinational.
module hp_first_set #(
    parameter int N = hit_pool_pkg::DEF_SLOTS
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    // Scan upward and keep only the first request seen.
    always_comb begin
        logic seen;
        seen = 1'b0;
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                pick[i] = 1'b1;
                seen    = 1'b1;
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/hp_slot_bank.sv
// Bank of hit record slots. Each slot stores one record, ages it against
// the time base and, at latency + 1, either marks it ready or frees it
// according to the trigger history bit of its leading stamp.
// Assumes: alloc only targets free slots, release only targets ready slots.
module hp_slot_bank
    import hit_pool_pkg::*;
#(
    parameter int N      = DEF_SLOTS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int TS_W   = DEF_TS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           alloc,
    input  logic [N-1:0]           release_sel,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [TS_W-1:0]        in_lead,
    input  logic [TS_W-1:0]        in_trail,
    input  logic [TS_W-1:0]        tnow,
    input  logic [TS_W-1:0]        lat,
    input  logic [(1<<TS_W)-1:0]   hist,
    output logic [N-1:0]           occ,
    output logic [N-1:0]           rdy,
    output logic [N*ADDR_W-1:0]    addr_flat,
    output logic [N*TS_W-1:0]      lead_flat,
    output logic [N*TS_W-1:0]      trail_flat
);
    logic [TS_W-1:0] decide_age;

    assign decide_age = lat + 1'b1;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_state_e      st_q;
        logic [ADDR_W-1:0] addr_q;
        logic [TS_W-1:0]   lead_q;
        logic [TS_W-1:0]   trail_q;
        logic [TS_W-1:0]   age;
        logic              expire;

        assign age    = tnow - lead_q;
        assign expire = (st_q == SLOT_WAIT) && (age == decide_age);

        // Slot state: take, hand out, or resolve at the latency boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)              st_q <= SLOT_FREE;
            else if (alloc[g])       st_q <= SLOT_WAIT;
            else if (release_sel[g]) st_q <= SLOT_FREE;
            else if (expire)         st_q <= hist[lead_q] ? SLOT_READY : SLOT_FREE;
        end

        // Record payload captured when the slot is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= '0;
                lead_q  <= '0;
                trail_q <= '0;
            end else if (alloc[g]) begin
                addr_q  <= in_addr;
                lead_q  <= in_lead;
                trail_q <= in_trail;
            end
        end

        assign occ[g] = (st_q != SLOT_FREE);
        assign rdy[g] = (st_q == SLOT_READY);
        assign addr_flat[g*ADDR_W +: ADDR_W] = addr_q;
        assign lead_flat[g*TS_W +: TS_W]     = lead_q;
        assign trail_flat[g*TS_W +: TS_W]    = trail_q;
    end

endmodule

// File: rtl/hit_latency_pool.sv
// Latency-matched end-of-column hit buffer pool (top).
// Accepts hit records, holds them for the trigger latency, keeps those whose
// time slot was triggered and streams them out lowest slot first.
// Assumes: hit_lead is taken from time_now; cfg_latency is 1..127 and
// changes only while the pool is empty.
module hit_latency_pool
    import hit_pool_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int TS_W   = DEF_TS_W,
    parameter int OVF_W  = DEF_OVF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   cfg_latency,
    input  logic              cfg_self_trig,
    input  logic              trig_in,
    input  logic              gor_in,
    input  logic              hit_valid,
    output logic              hit_ready,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic [TS_W-1:0]   hit_lead,
    input  logic [TS_W-1:0]   hit_trail,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TS_W-1:0]   out_lead,
    output logic [TS_W-1:0]   out_trail,
    output logic [TS_W-1:0]   time_now,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam int HIST_N = 1 << TS_W;

    logic [HIST_N-1:0]       hist;
    logic [SLOTS-1:0]        slot_occ;
    logic [SLOTS-1:0]        slot_rdy;
    logic [SLOTS-1:0]        free_pick;
    logic [SLOTS-1:0]        rdy_pick;
    logic [SLOTS-1:0]        alloc;
    logic [SLOTS-1:0]        release_sel;
    logic                    any_free;
    logic                    any_rdy;
    logic [SLOTS*ADDR_W-1:0] addr_flat;
    logic [SLOTS*TS_W-1:0]   lead_flat;
    logic [SLOTS*TS_W-1:0]   trail_flat;
    logic [OVF_W-1:0]        ovf_q;

    hp_trigger_track #(.TS_W(TS_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat     (cfg_latency),
        .self_en (cfg_self_trig),
        .trig_in (trig_in),
        .gor_in  (gor_in),
        .tnow    (time_now),
        .hist    (hist)
    );

    hp_first_set #(.N(SLOTS)) u_free_sel (
        .req  (~slot_occ),
        .pick (free_pick),
        .any  (any_free)
    );

    hp_first_set #(.N(SLOTS)) u_rdy_sel (
        .req  (slot_rdy),
        .pick (rdy_pick),
        .any  (any_rdy)
    );

    assign hit_ready   = any_free;
    assign alloc       = free_pick & {SLOTS{hit_valid}};
    assign out_valid   = any_rdy;
    assign release_sel = rdy_pick & {SLOTS{out_ready}};

    hp_slot_bank #(.N(SLOTS), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (alloc),
        .release_sel (release_sel),
        .in_addr     (hit_addr),
        .in_lead     (hit_lead),
        .in_trail    (hit_trail),
        .tnow        (time_now),
        .lat         (cfg_latency),
        .hist        (hist),
        .occ         (slot_occ),
        .rdy         (slot_rdy),
        .addr_flat   (addr_flat),
        .lead_flat   (lead_flat),
        .trail_flat  (trail_flat)
    );

    // AND-OR mux of the selected ready slot onto the output word.
    always_comb begin
        out_addr  = '0;
        out_lead  = '0;
        out_trail = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rdy_pick[i]) begin
                out_addr  = addr_flat[i*ADDR_W +: ADDR_W];
                out_lead  = lead_flat[i*TS_W +: TS_W];
                out_trail = trail_flat[i*TS_W +: TS_W];
            end
        end
    end

    // Saturating count of clocks spent with every slot occupied.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovf_q <= '0;
        else if (!any_free && ovf_q != '1) ovf_q <= ovf_q + 1'b1;
    end

    assign ovf_count = ovf_q;

endmodule

// File: rtl/hp_pool_checker.sv
// Property checker for the hit buffer pool, attached by bind.
// Assumes: connected to the top's ports and its slot occupancy vectors.
module hp_pool_checker #(
    parameter int SLOTS  = hit_pool_pkg::DEF_SLOTS,
    parameter int TS_W   = hit_pool_pkg::DEF_TS_W,
    parameter int OVF_W  = hit_pool_pkg::DEF_OVF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SLOTS-1:0]  slot_occ,
    input logic [TS_W-1:0]   time_now,
    input logic [OVF_W-1:0]  ovf_count
);
    // R1
    full_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(slot_occ) == SLOTS) |-> !hit_ready);

    // R4
    ready_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ready |=> $stable(ovf_count));

    // R5
    ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_ready && ovf_count != '1) |=> (ovf_count == OVF_W'($past(ovf_count) + 1'b1)));

    // R8
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_now == TS_W'($past(time_now) + 1'b1)));

endmodule

bind hit_latency_pool hp_pool_checker #(
    .SLOTS (SLOTS),
    .TS_W  (TS_W),
    .OVF_W (OVF_W)
) u_pool_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ready (hit_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .slot_occ  (slot_occ),
    .time_now  (time_now),
    .ovf_count (ovf_count)
);

// File: tb/tb_hit_latency_pool.sv
module tb_hit_latency_pool;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NS = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_latency = 7'd10;
    logic        cfg_self_trig = 1'b0;
    logic        trig_in = 1'b0;
    logic        gor_in = 1'b0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [11:0] hit_addr = '0;
    logic [6:0]  hit_lead = '0;
    logic [6:0]  hit_trail = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_addr;
    logic [6:0]  out_lead;
    logic [6:0]  out_trail;
    logic [6:0]  time_now;
    logic [15:0] ovf_count;

    hit_latency_pool dut (
        .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency),
        .cfg_self_trig(cfg_self_trig), .trig_in(trig_in), .gor_in(gor_in),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_addr(hit_addr),
        .hit_lead(hit_lead), .hit_trail(hit_trail), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_lead(out_lead),
        .out_trail(out_trail), .time_now(time_now), .ovf_count(ovf_count)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int hs = 0;
    int addr_seq = 0;

    // Behavioural reference: per-slot record state and absolute times.
    int mst [NS];   // 0 free, 1 waiting, 2 ready
    int macc[NS];
    int maddr[NS];
    int mtrail[NS];
    int mc = 0;
    int movf = 0;
    bit trig_at[int];
    bit sched[int];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at t=%0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Reference update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) mst[i] = 0;
            mc = 0; movf = 0;
            trig_at.delete(); sched.delete();
        end else begin
            int lat, f, r;
            bit teff;
            lat = int'(cfg_latency);
            f = -1; r = -1;
            for (int i = NS-1; i >= 0; i--) begin
                if (mst[i] == 0) f = i;
                if (mst[i] == 2) r = i;
            end
            teff = trig_in || (cfg_self_trig && sched.exists(mc));
            if (sched.exists(mc)) sched.delete(mc);
            if (teff) trig_at[mc - lat] = 1'b1;
            if (cfg_self_trig && gor_in) sched[mc + lat] = 1'b1;
            for (int i = 0; i < NS; i++)
                if (mst[i] == 1 && mc == macc[i] + lat + 1)
                    mst[i] = trig_at.exists(macc[i]) ? 2 : 0;
            if (r >= 0 && out_ready) mst[r] = 0;
            if (f >= 0) begin
                if (hit_valid) begin
                    mst[f] = 1; macc[f] = mc;
                    maddr[f] = int'(hit_addr); mtrail[f] = int'(hit_trail);
                end
            end else if (movf < 65535) movf++;
            mc++;
        end
        if (rst_n && out_valid && out_ready) hs++;
    end

    // Compare every output with the reference away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int r; bit fr;
            r = -1; fr = 1'b0;
            for (int i = NS-1; i >= 0; i--) begin
                if (mst[i] == 2) r = i;
                if (mst[i] == 0) fr = 1'b1;
            end
            check(hit_ready == fr, "R1 hit_ready", int'(hit_ready), int'(fr));
            check(out_valid == (r >= 0), "R2/R3 out_valid", int'(out_valid), int'(r >= 0));
            if (r >= 0 && out_valid) begin
                check(int'(out_addr) == maddr[r], "R4 out_addr", int'(out_addr), maddr[r]);
                check(int'(out_lead) == macc[r] % 128, "R4 out_lead", int'(out_lead), macc[r] % 128);
                check(int'(out_trail) == mtrail[r], "R4 out_trail", int'(out_trail), mtrail[r]);
            end
            check(int'(ovf_count) == movf, "R5 ovf_count", int'(ovf_count), movf);
            check(int'(time_now) == mc % 128, "R8 time_now", int'(time_now), mc % 128);
        end
    end

    // Drive one edge's inputs, then wait for the next negative edge.
    task automatic tick(input bit hv, input bit tr, input bit g, input bit ordy);
        hit_valid = hv;
        hit_addr  = 12'(addr_seq * 37 + 5);
        hit_lead  = time_now;
        hit_trail = 7'(addr_seq * 3 + 1);
        trig_in   = tr;
        gor_in    = g;
        out_ready = ordy;
        if (hv) addr_seq++;
        @(negedge clk);
    endtask

    task automatic do_reset(input int lat, input bit self_en);
        @(negedge clk);
        rst_n = 1'b0;
        hit_valid = 0; trig_in = 0; gor_in = 0; out_ready = 0;
        cfg_latency = 7'(lat);
        cfg_self_trig = self_en;
        repeat (2) @(negedge clk);
        // R9 reset state
        check(hit_ready == 1'b1, "R9 hit_ready", int'(hit_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        check(ovf_count == 16'd0, "R9 ovf_count", int'(ovf_count), 0);
        check(time_now == 7'd0, "R9 time_now", int'(time_now), 0);
        rst_n = 1'b1;
        hs = 0;
    endtask

    initial begin
        // R2 R3 R7: five hits, triggers for the 1st, 3rd, 5th pending together.
        do_reset(20, 1'b0);
        for (int k = 0; k < 60; k++)
            tick(k < 5, (k == 20 || k == 22 || k == 24), 1'b0, 1'b1);
        check(hs == 3, "R7 selected readouts", hs, 3);

        // R1 R4 R5: fill the pool, hold the output, then drain it slowly.
        do_reset(40, 1'b0);
        for (int k = 0; k < 150; k++)
            tick(k < 30, (k >= 40 && k < 64), 1'b0, (k >= 80) && (k % 2 == 0));
        check(hs == 24, "R4 drained records", hs, 24);
        check(ovf_count == 16'd57, "R5 full clocks", int'(ovf_count), 57);

        // R6: self-triggers, then the mode switched off.
        do_reset(12, 1'b1);
        for (int k = 0; k < 90; k++) begin
            if (k == 45) cfg_self_trig = 1'b0;
            tick(k == 3 || k == 5 || k == 30 || k == 50, 1'b0,
                 k == 3 || k == 30 || k == 50, 1'b1);
        end
        check(hs == 2, "R6 self-triggered readouts", hs, 2);

        // R2 boundary: latency 1.
        do_reset(1, 1'b0);
        for (int k = 0; k < 20; k++)
            tick(k < 4, (k == 1 || k == 2), 1'b0, 1'b1);
        check(hs == 2, "R2 latency 1 readouts", hs, 2);

        // R2 R8 boundary: latency 127 across the time-base wrap.
        do_reset(127, 1'b0);
        for (int k = 0; k < 140; k++)
            tick(k < 2, k == 127, 1'b0, 1'b1);
        check(hs == 1, "R2 latency 127 readouts", hs, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000ns;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule